// File: doc/BRIEF.md
# CAN FD Dual-Rate Bit Timing Unit

This block divides the system clock into time quanta and places a single sample strobe in every bit on a CAN bus that runs at two bit rates. It watches an already synchronized receive input (0 = dominant, 1 = recessive) for falling edges. While the frame logic reports the bus as idle, such an edge is taken as start of frame and restarts the bit timer (hard synchronization). Inside a frame, an edge shifts the bit boundary by a bounded amount (resynchronization) so that the sample point tracks the transmitter's clock.

Two independent timing sets, one for the arbitration (nominal) rate and one for the data rate, are held on input ports. Each set gives the clocks per quantum, the propagation segment, phase segment 1, phase segment 2 and the resynchronization jump width. The frame logic asks for the fast set after it has seen a recessive rate-switch bit, and asks for the slow set near the end of the frame. Each request takes effect from the start of the next bit. The unit outputs a one-cycle sample strobe, the bit value taken at that strobe, and a flag that shows which set is active.

Top module: `cfd_bit_timer`

## Requirements
- R1: During reset and in the first cycle after it, `sample_stb` is 0, `sample_bit` is 1 (recessive) and `fast_active` is 0.
- R2: With `bus_idle` high, a falling `rx_in` registered at clock edge H restarts the bit. The first strobe is then high in the cycle that follows clock edge H + (1+prop+ph1)·brp. In the 250 kbit/s style setting (brp 4, prop 7, ph1 3), this is 11 quanta after the edge.
- R3: Without further falling edges, strobes repeat every (1+prop+ph1+ph2)·brp clocks, and each is exactly one cycle wide.
- R4: `sample_bit` holds the value of `rx_in` in the cycle where the strobe was produced.
- R5: Inside a frame, a falling edge in phase segment 1 (quantum index q after the sync quantum, with prop < q ≤ end of segment 1) lengthens segment 1 of this bit by min(q, sjw) quanta.
- R6: Inside a frame, a falling edge in phase segment 2 with early error e = quanta left in the bit, counting the current one, restarts the bit at that edge when e ≤ sjw. Otherwise it shortens phase segment 2 of this bit by sjw quanta.
- R7: Falling edges in the sync quantum or in the propagation segment (quantum index 1..prop) are ignored as noise.
- R8: At most one resynchronization is taken per bit. No resynchronization is taken for an edge while `tx_dom` is high.
- R9: A pulse on `fast_req` makes the data set active from the next bit onward, and `fast_active` rises at that bit boundary. A pulse on `slow_req` returns to the nominal set at the next boundary, and slow wins if both are pending. A hard synchronization always selects the nominal set.
- R10: Legal settings are brp ≥ 1 (clocks per quantum, so every quantum spans at least one clock), 1 ≤ prop+ph1 ≤ 64, 1 ≤ ph2 ≤ 32 and 1 ≤ sjw ≤ ph2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Synchronized bus level, 0 dominant |
| tx_dom | input | 1 | This node is driving dominant |
| bus_idle | input | 1 | Frame logic reports idle bus |
| fast_req | input | 1 | Pulse: use data set from next bit |
| slow_req | input | 1 | Pulse: use nominal set from next bit |
| nom_brp | input | 8 | Nominal clocks per quantum |
| nom_prop | input | 7 | Nominal propagation segment, quanta |
| nom_ph1 | input | 7 | Nominal phase segment 1, quanta |
| nom_ph2 | input | 6 | Nominal phase segment 2, quanta |
| nom_sjw | input | 6 | Nominal jump width, quanta |
| dat_brp | input | 8 | Data clocks per quantum |
| dat_prop | input | 7 | Data propagation segment |
| dat_ph1 | input | 7 | Data phase segment 1 |
| dat_ph2 | input | 6 | Data phase segment 2 |
| dat_sjw | input | 6 | Data jump width |
| sample_stb | output | 1 | One-cycle sample strobe |
| sample_bit | output | 1 | Bus value taken at the strobe |
| fast_active | output | 1 | Data set in use |

## Verification
Hard synchronization is run over four timing sets: the minimum segments at one clock per quantum, the 11-quantum reference, the 64/32-quantum extremes and a mid setting. A wrong clock-to-quantum scaling or a wrong segment sum moves the first strobe or the period. Single falling edges are then put in the propagation segment, in phase segment 1, and early in phase segment 2 with an error both below and above the jump width. Each case moves the next strobe by a different, precomputed amount, so a lengthening, a shortening, a restart and an ignored edge each show a distinct timing. A second edge in the same bit and an edge under own dominant transmission show whether the per-bit limit and the transmit mask hold. A switch to the data set and back is timed bit by bit.

// File: rtl/cfd_bt_pkg.sv
package cfd_bt_pkg;
  localparam int BRP_W     = 8;
  localparam int TSEG1_MAX = 64;
  localparam int PH2_MAX   = 32;
  localparam int T1_W      = $clog2(TSEG1_MAX + 1);
  localparam int P2_W      = $clog2(PH2_MAX + 1);
  localparam int Q_W       = $clog2(TSEG1_MAX + 2 * PH2_MAX + 2);

  typedef struct packed {
    logic [BRP_W-1:0] brp;
    logic [T1_W-1:0]  prop;
    logic [T1_W-1:0]  ph1;
    logic [P2_W-1:0]  ph2;
    logic [P2_W-1:0]  sjw;
  } seg_cfg_t;
endpackage

// File: rtl/cfd_bt_edge.sv
module cfd_bt_edge (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic fall_det
);
  logic rx_q;

  always_ff @(posedge clk) begin
    if (rst) rx_q <= 1'b1;
    else     rx_q <= rx_in;
  end

  assign fall_det = rx_q & ~rx_in;
endmodule

// File: rtl/cfd_bt_prescaler.sv
module cfd_bt_prescaler
  import cfd_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [BRP_W-1:0] brp,
  output logic [BRP_W-1:0] pcnt,
  output logic             tq_end
);
  assign tq_end = (pcnt >= (brp - BRP_W'(1)));

  always_ff @(posedge clk) begin
    if (rst || clr)  pcnt <= '0;
    else if (tq_end) pcnt <= '0;
    else             pcnt <= pcnt + BRP_W'(1);
  end
endmodule

// File: rtl/cfd_bt_rate.sv
module cfd_bt_rate
  import cfd_bt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     hard_sync,
  input  logic     new_bit,
  input  logic     fast_req,
  input  logic     slow_req,
  input  seg_cfg_t nom_cfg,
  input  seg_cfg_t dat_cfg,
  output logic     fast_active,
  output seg_cfg_t cfg_sel
);
  logic pend_fast, pend_slow, pf_n, ps_n;

  assign pf_n    = pend_fast | fast_req;
  assign ps_n    = pend_slow | slow_req;
  assign cfg_sel = fast_active ? dat_cfg : nom_cfg;

  always_ff @(posedge clk) begin
    if (rst || hard_sync) begin
      fast_active <= 1'b0;
      pend_fast   <= 1'b0;
      pend_slow   <= 1'b0;
    end else if (new_bit) begin
      if (ps_n)      fast_active <= 1'b0;
      else if (pf_n) fast_active <= 1'b1;
      pend_fast <= 1'b0;
      pend_slow <= 1'b0;
    end else begin
      pend_fast <= pf_n;
      pend_slow <= ps_n;
    end
  end
endmodule

// File: rtl/cfd_bt_seq.sv
module cfd_bt_seq
  import cfd_bt_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_in,
  input  logic           fall_det,
  input  logic           bus_idle,
  input  logic           tx_dom,
  input  logic           tq_end,
  input  seg_cfg_t       cfg,
  output logic           restart,
  output logic           new_bit,
  output logic           hard_sync,
  output logic [Q_W-1:0] qcnt,
  output logic           sample_stb,
  output logic           sample_bit
);
  logic [P2_W-1:0] ext, cut;
  logic            resynced;
  logic [Q_W-1:0]  tseg1, seg1_end, bit_end, sjw_q, early_err;
  logic            cand, late_do, early_do, bit_done;

  always_comb begin
    tseg1     = Q_W'(cfg.prop) + Q_W'(cfg.ph1);
    seg1_end  = tseg1 + Q_W'(ext);
    bit_end   = seg1_end + Q_W'(cfg.ph2) - Q_W'(cut);
    sjw_q     = Q_W'(cfg.sjw);
    early_err = bit_end + Q_W'(1) - qcnt;
    hard_sync = fall_det & bus_idle;
    cand      = fall_det & ~bus_idle & ~tx_dom & ~resynced;
    late_do   = cand && (qcnt > Q_W'(cfg.prop)) && (qcnt <= seg1_end);
    early_do  = cand && (qcnt > seg1_end);
    restart   = hard_sync | (early_do && (early_err <= sjw_q));
    bit_done  = tq_end && (qcnt == bit_end);
    new_bit   = restart | bit_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      qcnt       <= '0;
      ext        <= '0;
      cut        <= '0;
      resynced   <= 1'b0;
      sample_stb <= 1'b0;
      sample_bit <= 1'b1;
    end else begin
      sample_stb <= 1'b0;
      if (restart) begin
        qcnt     <= '0;
        ext      <= '0;
        cut      <= '0;
        resynced <= 1'b0;
      end else begin
        if (late_do) begin
          ext      <= (qcnt > sjw_q) ? cfg.sjw : P2_W'(qcnt);
          resynced <= 1'b1;
        end
        if (early_do) begin
          cut      <= cfg.sjw;
          resynced <= 1'b1;
        end
        if (bit_done) begin
          qcnt     <= '0;
          ext      <= '0;
          cut      <= '0;
          resynced <= 1'b0;
        end else if (tq_end) begin
          qcnt <= qcnt + Q_W'(1);
        end
        if (tq_end && (qcnt == seg1_end) && !late_do) begin
          sample_stb <= 1'b1;
          sample_bit <= rx_in;
        end
      end
    end
  end
endmodule

// File: rtl/cfd_bit_timer.sv
module cfd_bit_timer
  import cfd_bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_in,
  input  logic             tx_dom,
  input  logic             bus_idle,
  input  logic             fast_req,
  input  logic             slow_req,
  input  logic [BRP_W-1:0] nom_brp,
  input  logic [T1_W-1:0]  nom_prop,
  input  logic [T1_W-1:0]  nom_ph1,
  input  logic [P2_W-1:0]  nom_ph2,
  input  logic [P2_W-1:0]  nom_sjw,
  input  logic [BRP_W-1:0] dat_brp,
  input  logic [T1_W-1:0]  dat_prop,
  input  logic [T1_W-1:0]  dat_ph1,
  input  logic [P2_W-1:0]  dat_ph2,
  input  logic [P2_W-1:0]  dat_sjw,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             fast_active
);
  seg_cfg_t         nom_cfg, dat_cfg, cfg_sel;
  logic             fall_det, tq_end, restart, new_bit, hard_sync;
  logic [BRP_W-1:0] pcnt;
  logic [Q_W-1:0]   qcnt;

  assign nom_cfg = '{brp: nom_brp, prop: nom_prop, ph1: nom_ph1, ph2: nom_ph2, sjw: nom_sjw};
  assign dat_cfg = '{brp: dat_brp, prop: dat_prop, ph1: dat_ph1, ph2: dat_ph2, sjw: dat_sjw};

  cfd_bt_edge u_edge (
    .clk(clk), .rst(rst), .rx_in(rx_in), .fall_det(fall_det)
  );

  cfd_bt_prescaler u_pre (
    .clk(clk), .rst(rst), .clr(restart), .brp(cfg_sel.brp),
    .pcnt(pcnt), .tq_end(tq_end)
  );

  cfd_bt_rate u_rate (
    .clk(clk), .rst(rst), .hard_sync(hard_sync), .new_bit(new_bit),
    .fast_req(fast_req), .slow_req(slow_req),
    .nom_cfg(nom_cfg), .dat_cfg(dat_cfg),
    .fast_active(fast_active), .cfg_sel(cfg_sel)
  );

  cfd_bt_seq u_seq (
    .clk(clk), .rst(rst), .rx_in(rx_in), .fall_det(fall_det),
    .bus_idle(bus_idle), .tx_dom(tx_dom), .tq_end(tq_end), .cfg(cfg_sel),
    .restart(restart), .new_bit(new_bit), .hard_sync(hard_sync),
    .qcnt(qcnt), .sample_stb(sample_stb), .sample_bit(sample_bit)
  );
endmodule

// File: rtl/cfd_bit_timer_chk.sv
module cfd_bit_timer_chk
  import cfd_bt_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             rx_in,
  input logic             sample_stb,
  input logic             sample_bit,
  input logic             fast_active,
  input logic             new_bit,
  input logic             hard_sync,
  input logic [Q_W-1:0]   qcnt,
  input logic [BRP_W-1:0] pcnt,
  input seg_cfg_t         cfg
);
  logic [T1_W:0] seg1_sum;
  assign seg1_sum = {1'b0, cfg.prop} + {1'b0, cfg.ph1};

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!sample_stb && sample_bit && !fast_active)); // R1

  AST_HARD_RESTART: assert property (@(posedge clk) disable iff (rst)
    hard_sync |=> (qcnt == '0 && pcnt == '0)); // R2

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb); // R3

  AST_BIT_IS_RX: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (sample_bit == $past(rx_in))); // R4

  AST_RATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !$stable(fast_active) |-> $past(new_bit)); // R9

  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (cfg.brp != '0) && (seg1_sum >= 1) && (seg1_sum <= TSEG1_MAX) &&
    (cfg.ph2 >= 1) && (cfg.ph2 <= PH2_MAX) &&
    (cfg.sjw >= 1) && (cfg.sjw <= cfg.ph2)); // R10
endmodule

bind cfd_bit_timer cfd_bit_timer_chk chk_i (
  .clk(clk), .rst(rst), .rx_in(rx_in), .sample_stb(sample_stb),
  .sample_bit(sample_bit), .fast_active(fast_active), .new_bit(new_bit),
  .hard_sync(hard_sync), .qcnt(qcnt), .pcnt(pcnt), .cfg(cfg_sel)
);

// File: tb/cfd_bit_timer_tb_top.sv
`timescale 1ns/1ps
module cfd_bit_timer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_in = 1'b1, tx_dom = 1'b0, bus_idle = 1'b1;
  logic fast_req = 1'b0, slow_req = 1'b0;
  logic [7:0] nom_brp = 8'd4, dat_brp = 8'd2;
  logic [6:0] nom_prop = 7'd7, nom_ph1 = 7'd3, dat_prop = 7'd2, dat_ph1 = 7'd3;
  logic [5:0] nom_ph2 = 6'd5, nom_sjw = 6'd2, dat_ph2 = 6'd2, dat_sjw = 6'd1;
  logic sample_stb, sample_bit, fast_active;

  always #5 clk = ~clk;

  cfd_bit_timer dut_i (
    .clk(clk), .rst(rst), .rx_in(rx_in), .tx_dom(tx_dom), .bus_idle(bus_idle),
    .fast_req(fast_req), .slow_req(slow_req),
    .nom_brp(nom_brp), .nom_prop(nom_prop), .nom_ph1(nom_ph1),
    .nom_ph2(nom_ph2), .nom_sjw(nom_sjw),
    .dat_brp(dat_brp), .dat_prop(dat_prop), .dat_ph1(dat_ph1),
    .dat_ph2(dat_ph2), .dat_sjw(dat_sjw),
    .sample_stb(sample_stb), .sample_bit(sample_bit), .fast_active(fast_active)
  );

  // brp, prop, ph1, ph2, sjw
  localparam int VEC [4][5] = '{
    '{4, 7, 3, 5, 2}, '{1, 1, 1, 1, 1}, '{3, 40, 24, 32, 8}, '{2, 5, 2, 3, 2}};

  int cyc = 0, tests = 0, fails = 0, n = 0, h = 0;
  int stb_cyc [8];
  logic stb_val [8];
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sample_stb && n < 8) begin
      stb_cyc[n] = cyc;
      stb_val[n] = sample_bit;
      n = n + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; rx_in = 1'b1; bus_idle = 1'b1; tx_dom = 1'b0;
    fast_req = 1'b0; slow_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic hard_start();
    rx_in = 1'b0;
    h = cyc + 1;
    @(posedge clk);
    n = 0;
    @(negedge clk);
    bus_idle = 1'b0;
  endtask

  task automatic upto(input int k);
    while (cyc < h + k - 1) @(negedge clk);
  endtask

  task automatic obs_at(input int k);
    while (cyc < h + k) @(negedge clk);
  endtask

  task automatic wait_stb(input int cnt);
    int guard = 0;
    while (n < cnt && guard < 3000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic set_nom(input int b, input int p, input int p1, input int p2, input int s);
    nom_brp = 8'(b); nom_prop = 7'(p); nom_ph1 = 7'(p1);
    nom_ph2 = 6'(p2); nom_sjw = 6'(s);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R1 stb in reset", int'(sample_stb), 0);
    check("R1 bit in reset", int'(sample_bit), 1);
    check("R1 fast in reset", int'(fast_active), 0);

    for (int v = 0; v < 4; v++) begin
      set_nom(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      do_reset();
      hard_start();
      wait_stb(2);
      check("R2 first sample delay", stb_cyc[0] - h,
            (1 + VEC[v][1] + VEC[v][2]) * VEC[v][0]);
      check("R3 bit period", stb_cyc[1] - stb_cyc[0],
            (1 + VEC[v][1] + VEC[v][2] + VEC[v][3]) * VEC[v][0]);
      check("R4 sampled dominant", int'(stb_val[0]), 0);
    end

    set_nom(4, 7, 3, 5, 2);

    // R5: late edge at quantum 8, clamped to sjw 2
    do_reset(); hard_start();
    upto(10); rx_in = 1'b1;
    upto(34); rx_in = 1'b0;
    wait_stb(1);
    check("R5 late edge lengthens seg1", stb_cyc[0] - h, 52);
    check("R4 sampled after late edge", int'(stb_val[0]), 0);

    // R6: early edge, error 2 <= sjw -> restart
    do_reset(); hard_start();
    upto(10); rx_in = 1'b1;
    upto(58); rx_in = 1'b0;
    wait_stb(2);
    check("R4 sampled recessive", int'(stb_val[0]), 1);
    check("R6 early small error restarts", stb_cyc[1] - h, 102);

    // R6: early edge, error 4 > sjw -> ph2 shortened by 2
    do_reset(); hard_start();
    upto(10); rx_in = 1'b1;
    upto(50); rx_in = 1'b0;
    wait_stb(2);
    check("R6 early large error shortens ph2", stb_cyc[1] - h, 100);

    // R7: edge in propagation segment ignored
    do_reset(); hard_start();
    upto(10); rx_in = 1'b1;
    upto(22); rx_in = 1'b0;
    wait_stb(2);
    check("R7 prop edge ignored", stb_cyc[0] - h, 44);
    check("R7 prop edge ignored period", stb_cyc[1] - h, 108);

    // R8: edge under own dominant transmission ignored
    do_reset(); hard_start();
    upto(10); rx_in = 1'b1;
    upto(30); tx_dom = 1'b1;
    upto(34); rx_in = 1'b0;
    upto(40); tx_dom = 1'b0;
    wait_stb(1);
    check("R8 tx dominant edge ignored", stb_cyc[0] - h, 44);

    // R8: second edge in the same bit ignored
    do_reset(); hard_start();
    upto(10); rx_in = 1'b1;
    upto(34); rx_in = 1'b0;
    upto(38); rx_in = 1'b1;
    upto(66); rx_in = 1'b0;
    wait_stb(2);
    check("R8 first resync taken", stb_cyc[0] - h, 52);
    check("R8 second resync blocked", stb_cyc[1] - h, 116);

    // R9: switch to data set and back
    do_reset(); hard_start();
    upto(46); fast_req = 1'b1;
    @(negedge clk); fast_req = 1'b0;
    obs_at(63);
    check("R9 still nominal before boundary", int'(fast_active), 0);
    obs_at(64);
    check("R9 fast at boundary", int'(fast_active), 1);
    upto(86); slow_req = 1'b1;
    @(negedge clk); slow_req = 1'b0;
    obs_at(95);
    check("R9 fast held to boundary", int'(fast_active), 1);
    obs_at(96);
    check("R9 nominal after slow request", int'(fast_active), 0);
    wait_stb(4);
    check("R9 first data sample", stb_cyc[1] - h, 76);
    check("R9 data bit period", stb_cyc[2] - stb_cyc[1], 16);
    check("R9 nominal sample after return", stb_cyc[3] - h, 140);

    // R10: legal extreme settings were used in the vector table (64/32 quanta, brp 1)
    check("R10 extreme set sampled", int'(n >= 4), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule